// File: doc/BRIEF.md
# Flash Command Unlock Sequencer

This block sits behind the write path of a byte-wide flash array and turns a stream of bus write cycles into instructions for the program/erase controller. Each write cycle carries a 19-bit address and a data byte. An instruction is accepted only after a fixed two-cycle unlock code. Program and signature instructions follow that code directly. An erase needs a setup byte, a second unlock code and a confirm byte on the sixth cycle. A cycle that does not fit the expected step sends the sequencer back to read-array mode, and the cycle is not counted as the start of a new sequence.

The outputs are one-cycle request pulses and a read-select code. A program request carries its address and data. A chip-erase request stands alone. A block-erase request carries a 3-bit block index. A reset pulse marks the reset instruction. The read-select code, taken from the current bus address, tells the read path whether to return array data, the manufacturer code, the device code or a block protection status. Requests are not issued while the controller reports busy, but the sequence that asked for them is still used up.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset all request outputs are low, `rd_mode` is 0 (array), and the sequencer waits for a first unlock cycle.
- R2: The unlock code is data AAh with address bits 14..0 = 5555h, then data 55h with bits 14..0 = 2AAAh. Address bits 18..15 are ignored. Data A0h at 5555h on cycle three, then any write on cycle four, raises `prog_req` for one cycle in the cycle after the fourth write. At the same time `prog_addr` and `prog_data` hold that write's address and data.
- R3: The program data cycle accepts any byte, including F0h and 00h, as data and not as a command.
- R4: Data 90h at 5555h on cycle three enters signature mode. While in it, `rd_mode` follows the bus address: A0=A1=A6=0 gives 1 (manufacturer), A0=1 with A1=A6=0 gives 2 (device), and A1=1 with A0=A6=0 gives 3 (protection status of the block on A18..A16). Any other combination gives 0.
- R5: Outside signature mode `rd_mode` is 0. Any write cycle other than a completed signature instruction leaves signature mode.
- R6: The sequence unlock, 80h at 5555h, unlock, 10h at 5555h raises `chip_erase_req` for one cycle after the sixth write.
- R7: The sequence unlock, 80h at 5555h, unlock, 30h at any address raises `blk_erase_req` for one cycle after the sixth write, with `blk_idx` equal to that write's address bits 18..16.
- R8: A wrong unlock byte or address, or a wrong command or confirm byte, returns the sequencer to read-array mode with no request. The offending write does not count as a first unlock cycle.
- R9: Data F0h in any state except the program data cycle raises `seq_reset` for one cycle and returns to read-array mode, with or without unlock cycles in front of it.
- R10: Data 00h during command entry (not as program data) aborts the sequence with no request and no `seq_reset`.
- R11: While `ctl_busy` is high during the final write, no program or erase request is raised, and the sequencer still returns to read-array mode.
- R12: At most one of the four request outputs is high in any cycle, and a cycle without a write raises none of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one cycle per bus write |
| bus_addr | input | 19 | Bus address, used for writes and read selection |
| bus_data | input | 8 | Write data byte |
| ctl_busy | input | 1 | Program/erase controller busy |
| rd_mode | output | 2 | Read select: 0 array, 1 manufacturer, 2 device, 3 protection |
| prog_req | output | 1 | One-cycle program request |
| prog_addr | output | 19 | Address to program |
| prog_data | output | 8 | Byte to program |
| chip_erase_req | output | 1 | One-cycle chip-erase request |
| blk_erase_req | output | 1 | One-cycle block-erase request |
| blk_idx | output | 3 | Block to erase |
| seq_reset | output | 1 | One-cycle reset-instruction pulse |

## Verification
The hardest situation to reach from the ports is a deviation deep inside an erase sequence: a bad second unlock on cycle four or five, or a wrong confirm on cycle six. The same goes for a write that would have been a valid first unlock arriving while the sequencer is somewhere else. Random stimulus reaches these by drawing mostly from the exact coded cycles and command bytes, with random upper address bits and a random busy flag, so that long valid prefixes happen often and break off at every position. Directed sequences cover each abort point, F0h and 00h as program data, and every signature read pattern.

// File: rtl/fcu_pkg.sv
package fcu_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_UNL1,
    ST_UNL2,
    ST_PROG,
    ST_ERS0,
    ST_ERS1,
    ST_ERS2
  } seq_st_t;

  localparam logic [1:0] RD_ARRAY = 2'd0;
  localparam logic [1:0] RD_MFR   = 2'd1;
  localparam logic [1:0] RD_DEV   = 2'd2;
  localparam logic [1:0] RD_PROT  = 2'd3;

  typedef struct packed {
    logic unl1;
    logic unl2;
    logic rst_cmd;
    logic zero;
    logic sig_cmd;
    logic prog_cmd;
    logic ers_cmd;
    logic chip_conf;
    logic blk_conf;
  } cyc_cls_t;

  function automatic logic [1:0] sig_select(input logic a0, input logic a1, input logic a6);
    if (!a1 && !a6)           return a0 ? RD_DEV : RD_MFR;
    else if (a1 && !a0 && !a6) return RD_PROT;
    else                       return RD_ARRAY;
  endfunction

endpackage

// File: rtl/fcu_decode.sv
module fcu_decode
  import fcu_pkg::*;
#(
  parameter int CODE_W = 15,
  parameter int DATA_W = 8,
  parameter logic [CODE_W-1:0] UNL1_ADDR = 15'h5555,
  parameter logic [CODE_W-1:0] UNL2_ADDR = 15'h2AAA,
  parameter logic [DATA_W-1:0] UNL1_DATA = 8'hAA,
  parameter logic [DATA_W-1:0] UNL2_DATA = 8'h55,
  parameter logic [DATA_W-1:0] RST_CODE  = 8'hF0,
  parameter logic [DATA_W-1:0] SIG_CODE  = 8'h90,
  parameter logic [DATA_W-1:0] PROG_CODE = 8'hA0,
  parameter logic [DATA_W-1:0] ERS_CODE  = 8'h80,
  parameter logic [DATA_W-1:0] CHIP_CONF = 8'h10,
  parameter logic [DATA_W-1:0] BLK_CONF  = 8'h30
) (
  input  logic [CODE_W-1:0] addr_lo,
  input  logic [DATA_W-1:0] data,
  output cyc_cls_t          cls
);

  logic at_u1, at_u2;
  assign at_u1 = (addr_lo == UNL1_ADDR);
  assign at_u2 = (addr_lo == UNL2_ADDR);

  always_comb begin
    cls.unl1      = at_u1 && (data == UNL1_DATA);
    cls.unl2      = at_u2 && (data == UNL2_DATA);
    cls.rst_cmd   = (data == RST_CODE);
    cls.zero      = (data == '0);
    cls.sig_cmd   = at_u1 && (data == SIG_CODE);
    cls.prog_cmd  = at_u1 && (data == PROG_CODE);
    cls.ers_cmd   = at_u1 && (data == ERS_CODE);
    cls.chip_conf = at_u1 && (data == CHIP_CONF);
    cls.blk_conf  = (data == BLK_CONF);
  end

endmodule

// File: rtl/fcu_seq.sv
module fcu_seq
  import fcu_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8,
  parameter int BLK_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              busy,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  input  cyc_cls_t          cls,
  output logic              prog_req,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [DATA_W-1:0] prog_data,
  output logic              chip_req,
  output logic              blk_req,
  output logic [BLK_W-1:0]  blk_idx,
  output logic              rst_req,
  output logic              sig_on
);

  localparam int BLK_LSB = ADDR_W - BLK_W;

  seq_st_t st, nxt;
  logic take_prog, take_chip, take_blk, take_rst, take_sig;

  always_comb begin
    nxt       = st;
    take_prog = 1'b0;
    take_chip = 1'b0;
    take_blk  = 1'b0;
    take_rst  = 1'b0;
    take_sig  = 1'b0;
    if (wr_en) begin
      nxt = ST_IDLE;
      if (st == ST_PROG) begin
        take_prog = 1'b1;
      end else if (cls.rst_cmd) begin
        take_rst = 1'b1;
      end else begin
        case (st)
          ST_IDLE: if (cls.unl1) nxt = ST_UNL1;
          ST_UNL1: if (cls.unl2) nxt = ST_UNL2;
          ST_UNL2: begin
            if (cls.sig_cmd)       take_sig = 1'b1;
            else if (cls.prog_cmd) nxt = ST_PROG;
            else if (cls.ers_cmd)  nxt = ST_ERS0;
          end
          ST_ERS0: if (cls.unl1) nxt = ST_ERS1;
          ST_ERS1: if (cls.unl2) nxt = ST_ERS2;
          ST_ERS2: begin
            if (cls.chip_conf)     take_chip = 1'b1;
            else if (cls.blk_conf) take_blk = 1'b1;
          end
          default: nxt = ST_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      prog_req  <= 1'b0;
      prog_addr <= '0;
      prog_data <= '0;
      chip_req  <= 1'b0;
      blk_req   <= 1'b0;
      blk_idx   <= '0;
      rst_req   <= 1'b0;
      sig_on    <= 1'b0;
    end else begin
      st       <= nxt;
      prog_req <= take_prog && !busy;
      chip_req <= take_chip && !busy;
      blk_req  <= take_blk && !busy;
      rst_req  <= take_rst;
      if (wr_en) sig_on <= take_sig;
      if (take_prog) begin
        prog_addr <= addr;
        prog_data <= data;
      end
      if (take_blk) blk_idx <= addr[BLK_LSB +: BLK_W];
    end
  end

  assert_req_onehot_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({prog_req, chip_req, blk_req, rst_req}));

  assert_no_write_no_req_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> !(prog_req || chip_req || blk_req || rst_req));

  assert_busy_blocks_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && busy) |=> !(prog_req || chip_req || blk_req));

  assert_prog_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    prog_req |-> (prog_data == $past(data) && prog_addr == $past(addr)));

  assert_blk_index_R7: assert property (@(posedge clk) disable iff (!rst_n)
    blk_req |-> blk_idx == $past(addr[BLK_LSB +: BLK_W]));

  assert_zero_aborts_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && cls.zero && st != ST_PROG) |=> (st == ST_IDLE && !rst_req));

  assert_sig_left_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !cls.sig_cmd) |=> !sig_on);

endmodule

// File: rtl/fcu_rdsel.sv
module fcu_rdsel
  import fcu_pkg::*;
(
  input  logic       sig_on,
  input  logic       a0,
  input  logic       a1,
  input  logic       a6,
  output logic [1:0] rd_mode
);

  assign rd_mode = sig_on ? sig_select(a0, a1, a6) : RD_ARRAY;

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import fcu_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8,
  parameter int CODE_W = 15,
  parameter int BLK_W  = 3,
  parameter logic [DATA_W-1:0] PROG_CODE = 8'hA0,
  parameter logic [DATA_W-1:0] BLK_CONF  = 8'h30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_data,
  input  logic              ctl_busy,
  output logic [1:0]        rd_mode,
  output logic              prog_req,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [DATA_W-1:0] prog_data,
  output logic              chip_erase_req,
  output logic              blk_erase_req,
  output logic [BLK_W-1:0]  blk_idx,
  output logic              seq_reset
);

  cyc_cls_t cls;
  logic     sig_on;

  fcu_decode #(
    .CODE_W(CODE_W), .DATA_W(DATA_W),
    .PROG_CODE(PROG_CODE), .BLK_CONF(BLK_CONF)
  ) u_decode (
    .addr_lo(bus_addr[CODE_W-1:0]),
    .data   (bus_data),
    .cls    (cls)
  );

  fcu_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BLK_W(BLK_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .busy     (ctl_busy),
    .addr     (bus_addr),
    .data     (bus_data),
    .cls      (cls),
    .prog_req (prog_req),
    .prog_addr(prog_addr),
    .prog_data(prog_data),
    .chip_req (chip_erase_req),
    .blk_req  (blk_erase_req),
    .blk_idx  (blk_idx),
    .rst_req  (seq_reset),
    .sig_on   (sig_on)
  );

  fcu_rdsel u_rdsel (
    .sig_on (sig_on),
    .a0     (bus_addr[0]),
    .a1     (bus_addr[1]),
    .a6     (bus_addr[6]),
    .rd_mode(rd_mode)
  );

endmodule

// File: tb/flash_cmd_seq_tb.sv
module flash_cmd_seq_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [18:0] bus_addr = '0;
  logic [7:0]  bus_data = '0;
  logic        ctl_busy = 1'b0;
  logic [1:0]  rd_mode;
  logic        prog_req, chip_erase_req, blk_erase_req, seq_reset;
  logic [18:0] prog_addr;
  logic [7:0]  prog_data;
  logic [2:0]  blk_idx;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_cmd_seq dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .bus_addr(bus_addr),
    .bus_data(bus_data), .ctl_busy(ctl_busy), .rd_mode(rd_mode),
    .prog_req(prog_req), .prog_addr(prog_addr), .prog_data(prog_data),
    .chip_erase_req(chip_erase_req), .blk_erase_req(blk_erase_req),
    .blk_idx(blk_idx), .seq_reset(seq_reset)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench model: 0 idle, 1 after AA, 2 after 55, 3 program data, 4 after 80, 5 after 2nd AA, 6 after 2nd 55
  int          m_st = 0;
  bit          m_sig = 0;
  bit          e_prog, e_chip, e_blk, e_rst;
  logic [18:0] e_pa;
  logic [7:0]  e_pd;
  logic [2:0]  e_bi;

  task automatic check(input string tag, input bit ok, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_rd(input bit sig, input logic [18:0] a);
    if (!sig) return 2'd0;
    case ({a[6], a[1], a[0]})
      3'b000:  return 2'd1;
      3'b001:  return 2'd2;
      3'b010:  return 2'd3;
      default: return 2'd0;
    endcase
  endfunction

  task automatic model(input logic [18:0] a, input logic [7:0] d, input bit bz);
    bit c1, c2;
    int ns;
    bit nsig;
    c1 = (a[14:0] == 15'h5555);
    c2 = (a[14:0] == 15'h2AAA);
    e_prog = 0; e_chip = 0; e_blk = 0; e_rst = 0;
    ns = 0; nsig = 0;
    if (m_st == 3) begin
      e_prog = !bz; e_pa = a; e_pd = d;
    end else if (d == 8'hF0) begin
      e_rst = 1;
    end else if ((m_st == 0 || m_st == 4) && c1 && d == 8'hAA) begin
      ns = m_st + 1;
    end else if ((m_st == 1 || m_st == 5) && c2 && d == 8'h55) begin
      ns = m_st + 1;
    end else if (m_st == 2 && c1) begin
      if (d == 8'h90) nsig = 1;
      else if (d == 8'hA0) ns = 3;
      else if (d == 8'h80) ns = 4;
    end else if (m_st == 6) begin
      if (c1 && d == 8'h10) e_chip = !bz;
      else if (d == 8'h30) begin e_blk = !bz; e_bi = a[18:16]; end
    end
    m_st = ns;
    m_sig = nsig;
  endtask

  task automatic wr(input string tag, input logic [18:0] a, input logic [7:0] d, input bit bz);
    bus_addr = a; bus_data = d; ctl_busy = bz; wr_en = 1'b1;
    model(a, d, bz);
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    check(tag, {prog_req, chip_erase_req, blk_erase_req, seq_reset} == {e_prog, e_chip, e_blk, e_rst},
          {prog_req, chip_erase_req, blk_erase_req, seq_reset}, {e_prog, e_chip, e_blk, e_rst});
    if (e_prog) check({tag, " prog addr/data"}, {prog_addr, prog_data} == {e_pa, e_pd},
                      {prog_addr, prog_data}, {e_pa, e_pd});
    if (e_blk) check({tag, " blk_idx"}, blk_idx == e_bi, blk_idx, e_bi);
  endtask

  task automatic rd_probe(input string tag, input logic [18:0] a);
    bus_addr = a; wr_en = 1'b0;
    #1;
    check(tag, rd_mode == exp_rd(m_sig, a), rd_mode, exp_rd(m_sig, a));
  endtask

  task automatic unlock(input string tag, input logic [3:0] hi);
    wr(tag, {hi, 15'h5555}, 8'hAA, 0);
    wr(tag, {hi, 15'h2AAA}, 8'h55, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1 reset requests", {prog_req, chip_erase_req, blk_erase_req, seq_reset} == 4'b0,
          {prog_req, chip_erase_req, blk_erase_req, seq_reset}, 0);
    rd_probe("R1 reset rd_mode", 19'h0);

    // R2: program with upper address bits set on unlock cycles
    unlock("R2 unlock", 4'hF);
    wr("R2 setup", {4'h9, 15'h5555}, 8'hA0, 0);
    wr("R2 program", 19'h4_1234, 8'h3C, 0);
    // R3: F0h and 00h as program data
    unlock("R3 unlock", 4'h0);
    wr("R3 setup", 19'h05555, 8'hA0, 0);
    wr("R3 data F0", 19'h7_0001, 8'hF0, 0);
    unlock("R3 unlock", 4'h3);
    wr("R3 setup", 19'h05555, 8'hA0, 0);
    wr("R3 data 00", 19'h2_FFFF, 8'h00, 0);

    // R4: signature read patterns
    unlock("R4 unlock", 4'h0);
    wr("R4 sig cmd", 19'h05555, 8'h90, 0);
    rd_probe("R4 mfr", 19'h7_0000);
    rd_probe("R4 dev", 19'h0_0001);
    rd_probe("R4 prot", 19'h5_0002);
    rd_probe("R4 other", 19'h0_0040);
    rd_probe("R4 other2", 19'h0_0003);
    // R5: any write leaves signature mode
    wr("R5 leave write", 19'h1_2345, 8'h77, 0);
    rd_probe("R5 array after write", 19'h0_0000);

    // R6: chip erase
    unlock("R6 unlock", 4'h0);
    wr("R6 setup", 19'h05555, 8'h80, 0);
    unlock("R6 unlock2", 4'hA);
    wr("R6 confirm", 19'h05555, 8'h10, 0);
    // R7: block erase
    unlock("R7 unlock", 4'h0);
    wr("R7 setup", 19'h05555, 8'h80, 0);
    unlock("R7 unlock2", 4'h0);
    wr("R7 confirm", 19'h5_0123, 8'h30, 0);

    // R8: wrong confirm, wrong second unlock, invalid write not a first unlock
    unlock("R8 unlock", 4'h0);
    wr("R8 setup", 19'h05555, 8'h80, 0);
    unlock("R8 unlock2", 4'h0);
    wr("R8 bad confirm", 19'h05555, 8'h20, 0);
    unlock("R8 unlock", 4'h0);
    wr("R8 setup", 19'h05555, 8'h80, 0);
    wr("R8 ok", 19'h05555, 8'hAA, 0);
    wr("R8 bad 2nd unlock", 19'h02AAB, 8'h55, 0);
    wr("R8 stray", 19'h02AAA, 8'h55, 0);
    wr("R8 no prog setup", 19'h05555, 8'hA0, 0);
    wr("R8 no program", 19'h0_0010, 8'h11, 0);
    wr("R8 after AA", 19'h05555, 8'hAA, 0);
    wr("R8 AA again aborts", 19'h05555, 8'hAA, 0);
    wr("R8 55 no advance", 19'h02AAA, 8'h55, 0);

    // R9: reset with and without unlock
    wr("R9 bare reset", 19'h1_0000, 8'hF0, 0);
    unlock("R9 unlock", 4'h0);
    wr("R9 reset after unlock", 19'h05555, 8'hF0, 0);
    unlock("R9 unlock", 4'h0);
    wr("R9 setup", 19'h05555, 8'h80, 0);
    wr("R9 reset mid erase", 19'h0, 8'hF0, 1);

    // R10: 00h aborts
    wr("R10 AA", 19'h05555, 8'hAA, 0);
    wr("R10 zero", 19'h02AAA, 8'h00, 0);
    wr("R10 55 after abort", 19'h02AAA, 8'h55, 0);
    wr("R10 A0 after abort", 19'h05555, 8'hA0, 0);
    wr("R10 no program", 19'h0_0123, 8'h5A, 0);

    // R11: busy suppresses requests
    unlock("R11 unlock", 4'h0);
    wr("R11 setup", 19'h05555, 8'hA0, 0);
    wr("R11 busy program", 19'h0_0777, 8'h12, 1);
    wr("R11 next write plain", 19'h0_0777, 8'h12, 0);
    unlock("R11 unlock", 4'h0);
    wr("R11 setup", 19'h05555, 8'h80, 0);
    unlock("R11 unlock2", 4'h0);
    wr("R11 busy blk", 19'h3_0000, 8'h30, 1);

    // R12 and all: random mix
    for (int i = 0; i < 3000; i++) begin
      logic [3:0]  hi;
      logic [18:0] a;
      logic [7:0]  d;
      bit bz;
      int k;
      hi = 4'($urandom);
      bz = ($urandom % 4) == 0;
      k = $urandom % 12;
      a = 19'($urandom);
      d = 8'($urandom);
      case (k)
        0, 1: begin a = {hi, 15'h5555}; d = 8'hAA; end
        2, 3: begin a = {hi, 15'h2AAA}; d = 8'h55; end
        4: begin a = {hi, 15'h5555}; d = 8'hA0; end
        5: begin a = {hi, 15'h5555}; d = 8'h80; end
        6: begin a = {hi, 15'h5555}; d = 8'h90; end
        7: begin a = {hi, 15'h5555}; d = 8'h10; end
        8: d = 8'h30;
        9: d = ($urandom % 2) ? 8'hF0 : 8'h00;
        default: ;
      endcase
      wr("R12 random", a, d, bz);
      if ($urandom % 3 == 0) rd_probe("R4 random read", 19'($urandom) & 19'h7_0043);
      if ($urandom % 5 == 0) begin
        @(negedge clk);
        check("R12 idle cycle", {prog_req, chip_erase_req, blk_erase_req, seq_reset} == 4'b0,
              {prog_req, chip_erase_req, blk_erase_req, seq_reset}, 0);
      end
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule